// File: doc/BRIEF.md
# Delayed-Parity Checker with Error Hold

This unit sits beside a registered command buffer and checks address parity. Each cycle it folds the covered bits of the registered command word down to one parity bit. It then pairs that bit with a separately supplied parity bit that trails the word by one or two clock cycles. The result drives two outputs:
- `ppo`, a partial-parity output that is high when the total count of ones is odd.
- `err_n`, an active-low error flag. Once it drops it is held low for a minimum number of cycles.

The control lines of the command register (termination, clock-enable and both chip selects) are not part of the covered word.

Two configuration inputs, held steady during operation, set the mode:
- `cfg_split` chooses between one wide covered word and a half-width word.
- `cfg_back` chooses the upper half in split mode. It also stretches the parity lag from one cycle to two.

The two-cycle lag is what allows a cascade. A second unit receives the first unit's `ppo` on its `par_in` and completes the check for the whole pair.

When both chip selects are high the unit is in standby, and both outputs hold their values. An asynchronous active-low reset clears all state.

Top module: `dlyparity_chk`

## Requirements
- R1: With `cfg_split`=0 all DATA_W (22) bits of `cmd_q` are covered. With `cfg_split`=1 and `cfg_back`=0 only bits 0..10 are covered. With `cfg_split`=1 and `cfg_back`=1 only bits 11..21 are covered. Bits outside the covered set never affect `ppo` or `err_n`.
- R2: With `cfg_back`=0, the `par_in` sampled at a clock edge covers the `cmd_q` sampled at that same edge. With `cfg_back`=1, it covers the `cmd_q` sampled one edge earlier. In both cases the result reaches `ppo` at the following edge.
- R3: On an updating edge, `ppo` becomes the XOR of the covered bits and the matching `par_in`, so it is 1 exactly when the combined count of ones is odd.
- R4: On an updating edge whose result is 1, `err_n` goes to 0 at that same edge.
- R5: Once `err_n` is 0 it stays 0 for at least HOLD_CYC (2) cycles. A further odd result during the hold restarts it. `err_n` returns to 1 only on an updating edge whose result is 0, after the hold has run out.
- R6: At an edge where `cs0_n` and `cs1_n` are both 1, `ppo`, `err_n` and the hold count keep their values.
- R7: `rst_n`=0 forces `ppo` to 0 and `err_n` to 1 at once, even while an error is being held, and clears the alignment pipeline to zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_split | input | 1 | 0: wide covered word, 1: half-width word |
| cfg_back | input | 1 | Upper half in split mode; parity lag of two cycles |
| cmd_q | input | DATA_W | Registered command word, control lines excluded |
| par_in | input | 1 | Delayed parity bit, or the upstream unit's `ppo` |
| cs0_n | input | 1 | First chip select, active low |
| cs1_n | input | 1 | Second chip select, active low |
| ppo | output | 1 | Partial parity: 1 when the combined count of ones is odd |
| err_n | output | 1 | Error flag, active low, held after an error |

## Verification
The bench runs long pseudo-random sequences in all four configurations. It computes the parity for each mode from its own bit-range rule and its own lag history. A wrong covered range or the wrong pipeline tap shows up as `ppo` mismatches from the first cycles of the affected mode.

Errors are injected sparsely so that the hold is both restarted and released. A counter that is one cycle short lets `err_n` rise a cycle early. A counter that ignores a new error during the hold releases the flag too soon.

Standby cycles land in the middle of error holds. Any update or count-down during standby makes the outputs drift from the held values. A reset issued while the flag is low must raise it at once.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Parity over the covered slice of a command word (width <= 64).
  function automatic logic covered_parity(input logic [63:0] word,
                                          input int unsigned width,
                                          input logic split,
                                          input logic upper);
    logic acc;
    int unsigned half;
    acc  = 1'b0;
    half = width / 2;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < width) begin
        if (!split || (upper ? (i >= half) : (i < half)))
          acc = acc ^ word[i];
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/dpc_reduce.sv
module dpc_reduce #(
  parameter int DATA_W = 22
) (
  input  logic [DATA_W-1:0] word,
  input  logic              split,
  input  logic              upper,
  output logic              word_par
);
  import dpc_pkg::*;

  always_comb begin
    word_par = covered_parity(64'(word), DATA_W, split, upper);
  end
endmodule

// File: rtl/dpc_align.sv
module dpc_align #(
  parameter  int LAG_MAX = 2,
  localparam int SEL_W   = (LAG_MAX > 1) ? $clog2(LAG_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_par,
  input  logic             par_in,
  input  logic [SEL_W-1:0] lag_sel,
  output logic             combined
);
  // tap[k] holds the word parity sampled k+1 edges ago
  logic [LAG_MAX-1:0] tap;
  logic               par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= par_in;
  end

  for (genvar k = 0; k < LAG_MAX; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[0] <= 1'b0;
        else        tap[0] <= word_par;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[k] <= 1'b0;
        else        tap[k] <= tap[k-1];
      end
    end
  end

  assign combined = par_q ^ tap[lag_sel];
endmodule

// File: rtl/dpc_errhold.sv
module dpc_errhold #(
  parameter  int HOLD_CYC = 2,
  localparam int CNT_W    = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic update_en,
  input  logic combined,
  output logic ppo,
  output logic err_n,
  output logic hold_active,
  output logic err_event
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign err_event   = update_en & combined;
  assign hold_active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppo   <= 1'b0;
      err_n <= 1'b1;
      cnt   <= '0;
    end else if (update_en) begin
      ppo <= combined;
      if (combined) begin
        err_n <= 1'b0;
        cnt   <= LOAD;
      end else if (hold_active) begin
        cnt <= cnt - 1'b1;
      end else begin
        err_n <= 1'b1;
      end
    end
  end

  AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(ppo) && $stable(err_n)); // R6
  AST_ERR_ON_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> !err_n && ppo); // R4
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n); // R5
  AST_RELEASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> !ppo); // R5
endmodule

// File: rtl/dlyparity_chk.sv
module dlyparity_chk #(
  parameter int DATA_W   = 22,
  parameter int LAG_MAX  = 2,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split,
  input  logic              cfg_back,
  input  logic [DATA_W-1:0] cmd_q,
  input  logic              par_in,
  input  logic              cs0_n,
  input  logic              cs1_n,
  output logic              ppo,
  output logic              err_n
);
  localparam int SEL_W = (LAG_MAX > 1) ? $clog2(LAG_MAX) : 1;

  logic word_par;
  logic combined;
  logic standby;
  logic hold_active;
  logic err_event;

  assign standby = cs0_n & cs1_n; // R6

  dpc_reduce #(.DATA_W(DATA_W)) u_reduce (
    .word     (cmd_q),
    .split    (cfg_split),
    .upper    (cfg_back),
    .word_par (word_par)
  );

  dpc_align #(.LAG_MAX(LAG_MAX)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_par (word_par),
    .par_in   (par_in),
    .lag_sel  (SEL_W'(cfg_back)),
    .combined (combined)
  );

  dpc_errhold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .update_en   (!standby),
    .combined    (combined),
    .ppo         (ppo),
    .err_n       (err_n),
    .hold_active (hold_active),
    .err_event   (err_event)
  );

  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !err_n); // R5
endmodule

// File: tb/tb_dlyparity_chk.sv
module tb_dlyparity_chk;
  localparam int W = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_split = 1'b0, cfg_back = 1'b0;
  logic [W-1:0] cmd_q = '0;
  logic par_in = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;
  logic ppo, err_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #4 clk = ~clk; // 125 MHz

  dlyparity_chk dut (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_back(cfg_back),
    .cmd_q(cmd_q), .par_in(par_in), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .ppo(ppo), .err_n(err_n)
  );

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  // Bench view of coverage: count ones inside the mode's bit range
  function automatic bit cov_par(input logic [W-1:0] d, input bit split, input bit back);
    int ones;
    int lo, hi;
    ones = 0;
    lo = (split && back) ? W / 2 : 0;
    hi = (split && !back) ? W / 2 : W;
    for (int i = lo; i < hi; i++) ones += int'(d[i]);
    return (ones % 2) == 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic got, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic run_mode(input bit split, input bit back, input int n, input string tag);
    logic [W-1:0] d1, d2;
    logic p1, exp_ppo, exp_err, good, comb;
    bit stby;
    int low_left;
    logic [31:0] r;
    d1 = '0; d2 = '0; p1 = 1'b0; low_left = 0;
    exp_ppo = 1'b0; exp_err = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_split = split; cfg_back = back;
    cmd_q = '0; par_in = 1'b0; cs0_n = 1'b0; cs1_n = 1'b0;
    #1;
    chk(ppo == 1'b0, {tag, " R7 reset ppo"}, ppo, 1'b0);
    chk(err_n == 1'b1, {tag, " R7 reset err_n"}, err_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      seed = xs(seed);
      r = seed;
      cmd_q = r[W-1:0];
      // R2: lag 1 covers this word, lag 2 covers the previous one
      good = back ? cov_par(d1, split, back) : cov_par(r[W-1:0], split, back);
      if (t >= n - 2) begin
        par_in = ~good;
        cs0_n = 1'b0; cs1_n = 1'b0;
      end else begin
        par_in = good ^ (r[26:24] == 3'd0);
        cs0_n = r[22]; cs1_n = r[23];
      end
      stby = cs0_n && cs1_n;
      if (!stby) begin
        comb = p1 ^ (back ? cov_par(d2, split, back) : cov_par(d1, split, back));
        exp_ppo = comb;
        if (comb) low_left = 2;
        else if (low_left > 0) low_left--;
        exp_err = (low_left == 0);
      end
      d2 = d1; d1 = r[W-1:0]; p1 = par_in;
      @(posedge clk);
      #2;
      if (stby) begin
        chk(ppo === exp_ppo, {tag, " R6 standby ppo"}, ppo, exp_ppo);
        chk(err_n === exp_err, {tag, " R6 standby err_n"}, err_n, exp_err);
      end else begin
        chk(ppo === exp_ppo, {tag, " R3 ppo"}, ppo, exp_ppo);
        chk(err_n === exp_err, {tag, " R4 R5 err_n"}, err_n, exp_err);
      end
    end
    // error is being held now; reset must clear it at once
    chk(err_n === 1'b0, {tag, " R4 forced error"}, err_n, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    chk(ppo == 1'b0, {tag, " R7 reset during hold ppo"}, ppo, 1'b0);
    chk(err_n == 1'b1, {tag, " R7 reset during hold err_n"}, err_n, 1'b1);
  endtask

  initial begin
    run_mode(1'b0, 1'b0, 400, "R1 R2 wide lag1");
    run_mode(1'b0, 1'b1, 400, "R1 R2 wide lag2 cascade");
    run_mode(1'b1, 1'b0, 400, "R1 R2 front half lag1");
    run_mode(1'b1, 1'b1, 400, "R1 R2 back half lag2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule